// File: doc/BRIEF.md
# One-Time-Programmable Protection Register Controller

This block holds a bank of one-time-programmable 16-bit words behind a command-driven write port. A program is a two-write sequence: a program command (0x00C0) written at the target address arms the block, and the next accepted write supplies the data for that armed address. Storage behaves like fuses. The committed word is the old contents ANDed with the written data, so bits can only fall from 1 to 0. An erased word reads 0xFFFF.

The bank contains two lock words. It also contains a 128-bit register. The lower half of that register holds a factory identifier, and the upper half is free for the user. After these come up to sixteen more 128-bit user registers, which together span offsets 0x080 to 0x109. A cleared lock bit write-protects its region for good; only a reset reloads the power-on contents. A rejected program is reported through sticky error flags in a status byte. A combinational read port returns any word in the bank.

Top module: `otp_prot_ctrl`

## Requirements
- R1: A write of 0x00C0 at an in-range address arms the block. The next accepted write's data is committed to the armed address after the busy window, whatever address that write carries.
- R2: A commit stores old AND data. Unprogrammed user words read 0xFFFF, and out-of-range reads return 0x0000.
- R3: status[7] (ready) is 0 for exactly BUSY_CYC cycles after the data write, and 1 otherwise. Every write that arrives while ready is 0 is ignored.
- R4: The valid space is 0x080 to 0x109. A program command outside it sets status[4] (program error) and does not arm the block.
- R5: A data write to a locked word sets both status[4] and status[1] (lock error). It leaves the word unchanged and does not raise busy.
- R6: Lock word 0 sits at 0x080 and resets to 0xFFFE. Its bit 0 (cleared) locks the identifier words 0x081 to 0x084, which reset to FACTORY_ID with the low 16 bits at 0x081. Its bit 1 locks the user words 0x085 to 0x088, and writing 0xFFFD there sets that lock.
- R7: Lock word 1 sits at 0x089. Its bit k, when 0, locks the eight words from 0x08A+8k to 0x091+8k.
- R8: Lock bits never return from 0 to 1 except through reset.
- R9: status[4] and status[1] stay set until a write of 0x0050 arrives while the block is neither busy nor armed. That write clears both flags.
- R10: While the block is idle, a write whose data is neither 0x00C0 nor 0x0050 has no effect on storage or status. After reset, status reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, reloads power-on contents |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 9 | Write address |
| wr_data | input | 16 | Write data or command code |
| rd_addr | input | 9 | Read address |
| rd_data | output | 16 | Word at rd_addr, combinational |
| status | output | 8 | bit7 ready, bit4 program error, bit1 lock error, others 0 |

## Verification
A wrong lock decode does not stay hidden. On the same data write it either raises the lock error in status with the stored word left unchanged, or it opens a busy window and the word changes where it should have been refused. A counter stuck in the wrong state shows up as a ready bit that returns one or more cycles early or late. A lost arm shows up as a word that never takes its data. The sticky flags are checked both across later successful programs and across a clear, so a flag that clears itself or refuses to clear is caught at the next status read.

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl #(
  parameter int          BUSY_CYC   = 4,
  parameter int          NUM_EXT    = 16,
  parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [8:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [8:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic [7:0]  status
);
  localparam int          NWORDS   = 10 + 8 * NUM_EXT;
  localparam int          IW       = $clog2(NWORDS);
  localparam int          CW       = $clog2(BUSY_CYC + 1);
  localparam logic [8:0]  BASE     = 9'h080;
  localparam logic [8:0]  NW9      = 9'(NWORDS);
  localparam logic [15:0] CMD_PROG = 16'h00C0;
  localparam logic [15:0] CMD_CLR  = 16'h0050;

  logic [15:0]   mem [NWORDS];
  logic          armed, busy, err_p, err_l;
  logic [8:0]    tgt;
  logic [15:0]   pend;
  logic [CW-1:0] cnt;
  logic [15:0]   lock0_w, lock1_w;

  assign lock0_w = mem[0];
  assign lock1_w = mem[9];

  logic [8:0] wr_idx, rd_idx, ext_off;
  logic       wr_ok, rd_ok, tgt_locked;

  assign wr_idx  = wr_addr - BASE;
  assign rd_idx  = rd_addr - BASE;
  assign wr_ok   = (wr_addr >= BASE) && (wr_idx < NW9);
  assign rd_ok   = (rd_addr >= BASE) && (rd_idx < NW9);
  assign ext_off = tgt - 9'd10;

  always_comb begin
    tgt_locked = 1'b0;
    if (tgt >= 9'd1 && tgt <= 9'd4)      tgt_locked = !lock0_w[0];
    else if (tgt >= 9'd5 && tgt <= 9'd8) tgt_locked = !lock0_w[1];
    else if (tgt >= 9'd10)               tgt_locked = !lock1_w[ext_off[6:3]];
  end

  assign rd_data = rd_ok ? mem[rd_idx[IW-1:0]] : 16'h0000;
  assign status  = {!busy, 2'b00, err_p, 2'b00, err_l, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= 16'hFFFF;
      mem[0] <= 16'hFFFE;
      for (int w = 0; w < 4; w++) mem[1 + w] <= FACTORY_ID[16*w +: 16];
      armed <= 1'b0;
      busy  <= 1'b0;
      err_p <= 1'b0;
      err_l <= 1'b0;
      tgt   <= '0;
      pend  <= '1;
      cnt   <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        mem[tgt[IW-1:0]] <= mem[tgt[IW-1:0]] & pend;
        busy <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (wr_en) begin
      if (armed) begin
        armed <= 1'b0;
        if (tgt_locked) begin
          err_p <= 1'b1;
          err_l <= 1'b1;
        end else begin
          pend <= wr_data;
          busy <= 1'b1;
          cnt  <= CW'(BUSY_CYC - 1);
        end
      end else if (wr_data == CMD_PROG) begin
        if (wr_ok) begin
          armed <= 1'b1;
          tgt   <= wr_idx;
        end else begin
          err_p <= 1'b1;
        end
      end else if (wr_data == CMD_CLR) begin
        err_p <= 1'b0;
        err_l <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/otp_prot_ctrl_chk.sv
module otp_prot_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [7:0]  status,
  input logic [15:0] lock0_w,
  input logic [15:0] lock1_w
);
  p_lock0_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(lock0_w)) & lock0_w) == 16'h0000)
    else $error("R8 lock word 0 bit restored");

  p_lock1_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(lock1_w)) & lock1_w) == 16'h0000)
    else $error("R8 lock word 1 bit restored");

  p_lockerr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[4])
    else $error("R5 lock error without program error");

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(wr_en && wr_data == 16'h0050))
    else $error("R9 program error cleared without clear command");

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |=> ($stable(status[4]) && $stable(status[1])))
    else $error("R3 status changed by a write during busy");

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status & 8'h6D) == 8'h00)
    else $error("R10 reserved status bits set");
endmodule

bind otp_prot_ctrl otp_prot_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .status  (status),
  .lock0_w (lock0_w),
  .lock1_w (lock1_w)
);

// File: tb/otp_prot_ctrl_tb.sv
module otp_prot_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [8:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  status;

  always #5 clk = ~clk;

  otp_prot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .status(status)
  );

  typedef struct {
    bit          is_st;
    logic [8:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0, pushed = 0, popped = 0;
  bit finished = 0;

  initial begin : monitor
    item_t it;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      if (!it.is_st) rd_addr = it.addr;
      #1;
      n_run++;
      if (it.is_st) begin
        if (status !== it.exp[7:0]) begin
          n_fail++;
          $display("FAIL %s status got %h expected %h", it.tag, status, it.exp[7:0]);
        end
      end else if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr %h got %h expected %h", it.tag, it.addr, rd_data, it.exp);
      end
      popped++;
    end
  end

  task automatic push(bit st, logic [8:0] a, logic [15:0] e, string tag);
    item_t it;
    it.is_st = st; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic exp_rd(logic [8:0] a, logic [15:0] e, string tag);
    push(1'b0, a, e, tag);
  endtask

  task automatic exp_st(logic [7:0] e, string tag);
    push(1'b1, 9'h0, {8'h00, e}, tag);
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    while (!status[7]) @(negedge clk);
  endtask

  task automatic prog(logic [8:0] a, logic [15:0] d);
    wr(a, 16'h00C0);
    wr(a, d);
    wait_ready();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin : driver
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    exp_st(8'h80, "R10 reset status");
    exp_rd(9'h080, 16'hFFFE, "R6 lock0 reset");
    exp_rd(9'h089, 16'hFFFF, "R7 lock1 reset");
    exp_rd(9'h081, 16'hCDEF, "R6 id word 0");
    exp_rd(9'h084, 16'h0123, "R6 id word 3");
    exp_rd(9'h085, 16'hFFFF, "R2 erased word");
    exp_rd(9'h010, 16'h0000, "R2 out-of-range read");

    // R1 / R3 busy window length
    wr(9'h085, 16'h00C0);
    wr(9'h085, 16'h1234);
    n = 0;
    while (!status[7]) begin n++; @(negedge clk); end
    n_run++;
    if (n != 4) begin
      n_fail++;
      $display("FAIL R3 busy cycles got %0d expected %0d", n, 4);
    end
    exp_rd(9'h085, 16'h1234, "R1 program commit");
    prog(9'h085, 16'hFF0F);
    exp_rd(9'h085, 16'h1204, "R2 and semantics");

    // R1 second write address is ignored
    wr(9'h086, 16'h00C0);
    wr(9'h0F0, 16'h00AA);
    wait_ready();
    exp_rd(9'h086, 16'h00AA, "R1 armed address used");
    exp_rd(9'h0F0, 16'hFFFF, "R1 other address untouched");

    // R5 factory id locked, R9 sticky
    prog(9'h082, 16'h0000);
    exp_st(8'h92, "R5 lock error on id");
    exp_rd(9'h082, 16'h89AB, "R5 id unchanged");
    prog(9'h087, 16'h7777);
    exp_st(8'h92, "R9 sticky across good program");
    exp_rd(9'h087, 16'h7777, "R9 good program still commits");
    wr(9'h000, 16'h0050);
    exp_st(8'h80, "R9 clear");

    // R4 out of range, R10 idle non-command ignored
    wr(9'h010, 16'h00C0);
    exp_st(8'h90, "R4 out of range command");
    wr(9'h085, 16'h0000);
    exp_rd(9'h085, 16'h1204, "R10 idle data write ignored");
    exp_st(8'h90, "R10 status unchanged");
    wr(9'h000, 16'h0050);
    prog(9'h10A, 16'h0000);
    exp_st(8'h90, "R4 just past end");
    wr(9'h000, 16'h0050);
    prog(9'h109, 16'h0F0F);
    exp_rd(9'h109, 16'h0F0F, "R4 last valid word");
    exp_st(8'h80, "R4 last valid no error");

    // R6 lock user half
    prog(9'h080, 16'hFFFD);
    exp_rd(9'h080, 16'hFFFC, "R6 lock0 bit1 set");
    prog(9'h088, 16'h0000);
    exp_st(8'h92, "R6 user half locked");
    exp_rd(9'h088, 16'hFFFF, "R6 user half unchanged");
    wr(9'h000, 16'h0050);

    // R7 lock1 bit 3
    prog(9'h089, 16'hFFF7);
    exp_rd(9'h089, 16'hFFF7, "R7 lock1 programmed");
    prog(9'h0A2, 16'h0000);
    exp_st(8'h92, "R7 ext reg 3 first word locked");
    wr(9'h000, 16'h0050);
    prog(9'h0A9, 16'h0000);
    exp_st(8'h92, "R7 ext reg 3 last word locked");
    wr(9'h000, 16'h0050);
    prog(9'h0A1, 16'h3333);
    exp_rd(9'h0A1, 16'h3333, "R7 ext reg 2 open");
    prog(9'h0AA, 16'h5555);
    exp_rd(9'h0AA, 16'h5555, "R7 ext reg 4 open");
    exp_st(8'h80, "R7 no error");

    // R8 permanence
    prog(9'h089, 16'hFFFF);
    exp_rd(9'h089, 16'hFFF7, "R8 lock1 not restored");
    prog(9'h080, 16'hFFFF);
    exp_rd(9'h080, 16'hFFFC, "R8 lock0 not restored");

    // R3 writes during busy ignored
    wr(9'h0AB, 16'h00C0);
    wr(9'h0AB, 16'h00FF);
    exp_st(8'h00, "R3 busy status");
    wr(9'h010, 16'h00C0);
    wait_ready();
    exp_st(8'h80, "R3 busy write ignored");
    exp_rd(9'h0AB, 16'h00FF, "R3 commit after busy");

    // reset reloads defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_rd(9'h089, 16'hFFFF, "R8 reset reloads lock1");
    exp_rd(9'h085, 16'hFFFF, "R2 reset reloads user word");

    summary();
  end
endmodule